// File: doc/BRIEF.md
# Flash Embedded-Operation Status Responder

This block is the device side of a small flash array while a program or erase operation runs inside it. A one-cycle start request carries the operation kind, a target address, the new data byte, the number of cycles the operation needs and a time budget. While the operation runs, any read that lands in the affected region gets a status byte instead of array contents. Status bit 6 flips after every read strobe, so a host can poll until two reads in a row agree. Status bit 5 reports a failure.

A program operation covers one byte. It ANDs the new data into the stored byte, so bits can only go from 1 to 0. An erase operation covers one sector and returns every byte in it to FFh. A program that tries to raise a cleared bit fails at once. An operation that is still running when the budget runs out fails by time-out. A failed operation stays busy and keeps reporting status until a clear command is given. The array is a small register file that powers up erased.

Top module: `flash_status_responder`

## Requirements
- R1: After reset, busy_o is 0 and every array byte reads back as FFh.
- R2: start_i while busy_o is 0 makes busy_o 1 from the next cycle. start_i while busy_o is 1 is ignored, and no byte it names is written.
- R3: While busy_o is 1, the read data for an address in the busy region is combinational. It is 0 except for bit 6 (toggle) and bit 5 (error). Bit 6 is 0 after start. It inverts once at each clock edge where rd_en_i is 1 and rd_addr_i is in the busy region, and it is unchanged otherwise.
- R4: A program (op_erase_i = 0) with work_i <= budget_i finishes after max(work_i, 1) edges; busy_o is 1 for exactly that many cycles. When work_i equals budget_i, completion wins. The target byte then holds old AND new.
- R5: A program whose new data has a 1 in any bit where the stored byte has 0 reports bit 5 = 1 from the first cycle of busy. It never completes, and the array is left unchanged.
- R6: If work_i > budget_i, bit 5 becomes 1 after max(budget_i, 1) edges and busy_o stays 1. This applies to both program and erase.
- R7: An erase (op_erase_i = 1) selects the sector given by op_addr_i[5:4], which is 16 bytes. During the erase, every address of that sector returns status. On completion, all 16 bytes read FFh.
- R8: Reads outside the busy region, and all reads while idle, return the stored array byte.
- R9: With bit 5 = 1, clear_i ends busy at the next edge and leaves the array unchanged. clear_i is ignored while idle or while an operation is running without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle operation request |
| op_erase_i | input | 1 | 1 = sector erase, 0 = byte program |
| op_addr_i | input | 6 | Target byte address (erase uses bits 5:4) |
| op_data_i | input | 8 | New data for a program |
| work_i | input | 8 | Cycles the operation needs |
| budget_i | input | 8 | Cycles allowed before time-out |
| clear_i | input | 1 | Clear command that ends a failed operation |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 6 | Read address |
| rd_data_o | output | 8 | Array byte or status byte |
| busy_o | output | 1 | Operation in progress or held after failure |

## Verification
A bad operation register shows up on the read port in the same cycle. A wrong target or sector turns status reads into array reads at the polled address, or the other way round. A toggle bit that does not flip, or flips without a strobe, changes bit 6 on the next read. A miscounted timer moves the fall of busy_o or the rise of bit 5 by at least one cycle. A faulty commit only shows at the first read of the affected bytes after completion. For that reason the bench reads those bytes right away.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } fsr_op_e;

    localparam int TOG_BIT = 6;
    localparam int ERR_BIT = 5;
endpackage

// File: rtl/fsr_timer.sv
module fsr_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] work_i,
    input  logic [CNT_W-1:0] budget_i,
    output logic             finish_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] work;
        logic [CNT_W-1:0] budget;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CNT_W:0] next_cnt;

    always_comb begin
        tmr_d    = tmr_q;
        next_cnt = {1'b0, tmr_q.cnt} + 1'b1;
        finish_o = run_i && (next_cnt >= {1'b0, tmr_q.work});
        expire_o = run_i && !finish_o && (next_cnt >= {1'b0, tmr_q.budget});
        if (load_i) begin
            tmr_d.cnt    = '0;
            tmr_d.work   = work_i;
            tmr_d.budget = budget_i;
        end else if (run_i) begin
            tmr_d.cnt = next_cnt[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/fsr_region.sv
module fsr_region #(
    parameter int ADDR_W = 6,
    parameter int SECT_W = 2
) (
    input  logic              busy_i,
    input  logic              erase_i,
    input  logic [ADDR_W-1:0] tgt_addr_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              hit_o
);
    localparam int SECT_LSB = ADDR_W - SECT_W;

    logic byte_match;
    logic sect_match;

    always_comb begin
        byte_match = (tgt_addr_i == rd_addr_i);
        sect_match = (tgt_addr_i[ADDR_W-1:SECT_LSB] == rd_addr_i[ADDR_W-1:SECT_LSB]);
        hit_o      = busy_i && (erase_i ? sect_match : byte_match);
    end
endmodule

// File: rtl/fsr_array.sv
module fsr_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int SECT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_i,
    input  logic              erase_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [ADDR_W-1:0] old_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [DATA_W-1:0] old_data_o
);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int SECT_LSB = ADDR_W - SECT_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic [ADDR_W-1:0] idx;
            idx      = ADDR_W'(i);
            mem_d[i] = mem_q[i];
            if (prog_i && (idx == wr_addr_i))
                mem_d[i] = mem_q[i] & wr_data_i;
            if (erase_i && (idx[ADDR_W-1:SECT_LSB] == wr_addr_i[ADDR_W-1:SECT_LSB]))
                mem_d[i] = '1;
        end
        rd_data_o  = mem_q[rd_addr_i];
        old_data_o = mem_q[old_addr_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end
endmodule

// File: rtl/flash_status_responder.sv
module flash_status_responder
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int SECT_W = 2,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_erase_i,
    input  logic [ADDR_W-1:0] op_addr_i,
    input  logic [DATA_W-1:0] op_data_i,
    input  logic [CNT_W-1:0]  work_i,
    input  logic [CNT_W-1:0]  budget_i,
    input  logic              clear_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o
);
    typedef struct packed {
        logic              busy;
        fsr_op_e           op;
        logic              err;
        logic              tog;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              load, run, finish, expire, hit;
    logic              commit_prog, commit_erase;
    logic [DATA_W-1:0] arr_rd, arr_old, status;
    logic              err_w;

    fsr_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .run_i    (run),
        .work_i   (work_i),
        .budget_i (budget_i),
        .finish_o (finish),
        .expire_o (expire)
    );

    fsr_region #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) region_i (
        .busy_i     (ctl_q.busy),
        .erase_i    (ctl_q.op == OP_ERASE),
        .tgt_addr_i (ctl_q.addr),
        .rd_addr_i  (rd_addr_i),
        .hit_o      (hit)
    );

    fsr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) array_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_i     (commit_prog),
        .erase_i    (commit_erase),
        .wr_addr_i  (ctl_q.addr),
        .wr_data_i  (ctl_q.data),
        .rd_addr_i  (rd_addr_i),
        .old_addr_i (op_addr_i),
        .rd_data_o  (arr_rd),
        .old_data_o (arr_old)
    );

    always_comb begin
        ctl_d        = ctl_q;
        load         = 1'b0;
        commit_prog  = 1'b0;
        commit_erase = 1'b0;
        run          = ctl_q.busy && !ctl_q.err;
        if (!ctl_q.busy) begin
            if (start_i) begin
                load       = 1'b1;
                ctl_d.busy = 1'b1;
                ctl_d.op   = op_erase_i ? OP_ERASE : OP_PROG;
                ctl_d.addr = op_addr_i;
                ctl_d.data = op_data_i;
                ctl_d.tog  = 1'b0;
                ctl_d.err  = !op_erase_i && (|(~arr_old & op_data_i));
            end
        end else begin
            if (rd_en_i && hit) ctl_d.tog = ~ctl_q.tog;
            if (ctl_q.err) begin
                if (clear_i) begin
                    ctl_d.busy = 1'b0;
                    ctl_d.err  = 1'b0;
                end
            end else if (finish) begin
                ctl_d.busy   = 1'b0;
                commit_prog  = (ctl_q.op == OP_PROG);
                commit_erase = (ctl_q.op == OP_ERASE);
            end else if (expire) begin
                ctl_d.err = 1'b1;
            end
        end
        status          = '0;
        status[TOG_BIT] = ctl_q.tog;
        status[ERR_BIT] = ctl_q.err;
        rd_data_o       = hit ? status : arr_rd;
        busy_o          = ctl_q.busy;
        err_w           = ctl_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              clear_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              busy_o,
    input logic              hit,
    input logic              err_w
);
    assert_start_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_toggle_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && hit && $past(busy_o && hit && rd_en_i)) |-> (rd_data_o[6] != $past(rd_data_o[6])));

    assert_toggle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && hit && $past(busy_o && hit && !rd_en_i)) |-> $stable(rd_data_o[6]));

    assert_status_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && hit) |-> (rd_data_o[7] == 1'b0 && rd_data_o[4:0] == '0));

    assert_error_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_w && !clear_i) |=> (err_w && busy_o));

    assert_clear_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_w && clear_i) |=> !busy_o);

    assert_fall_needs_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(!err_w || clear_i));
endmodule

bind flash_status_responder fsr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .clear_i   (clear_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .busy_o    (busy_o),
    .hit       (hit),
    .err_w     (err_w)
);

// File: tb/flash_status_responder_tb.sv
module flash_status_responder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       op_erase_i = 1'b0;
    logic [5:0] op_addr_i = '0;
    logic [7:0] op_data_i = '0;
    logic [7:0] work_i = '0;
    logic [7:0] budget_i = '0;
    logic       clear_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [5:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic       busy_o;

    always #2 clk = ~clk;

    flash_status_responder dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
        .op_addr_i(op_addr_i), .op_data_i(op_data_i), .work_i(work_i),
        .budget_i(budget_i), .clear_i(clear_i), .rd_en_i(rd_en_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .busy_o(busy_o)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [7:0] mem [64];
    bit m_busy, m_erase, m_err, m_tog;
    int m_addr, m_data, m_cnt, m_work, m_budget;
    logic [7:0] seen;

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic bit in_region(int a);
        if (!m_busy) return 0;
        if (m_erase) return (a >> 4) == (m_addr >> 4);
        return a == m_addr;
    endfunction

    function automatic int exp_rd(int a);
        if (in_region(a)) return (int'(m_tog) << 6) | (int'(m_err) << 5);
        return int'(mem[a]);
    endfunction

    task automatic tick(bit ren, int ra);
        int n;
        rd_en_i   = ren;
        rd_addr_i = 6'(ra);
        #1;
        seen = rd_data_o;
        chk("R2 busy", int'(busy_o), int'(m_busy));
        chk(in_region(ra) ? "R3 status read" : "R8 array read", int'(rd_data_o), exp_rd(ra));
        @(posedge clk);
        if (!m_busy) begin
            if (start_i) begin
                m_busy = 1; m_erase = op_erase_i; m_addr = op_addr_i; m_data = op_data_i;
                m_work = work_i; m_budget = budget_i; m_cnt = 0; m_tog = 0;
                m_err = !op_erase_i && (((~mem[op_addr_i]) & op_data_i) != 8'h00);
            end
        end else begin
            if (ren && in_region(ra)) m_tog = !m_tog;
            if (m_err) begin
                if (clear_i) begin m_busy = 0; m_err = 0; end
            end else begin
                n = m_cnt + 1;
                m_cnt = n;
                if (n >= m_work) begin
                    m_busy = 0;
                    if (m_erase) begin
                        for (int i = 0; i < 64; i++)
                            if ((i >> 4) == (m_addr >> 4)) mem[i] = 8'hFF;
                    end else begin
                        mem[m_addr] = mem[m_addr] & 8'(m_data);
                    end
                end else if (n >= m_budget) begin
                    m_err = 1;
                end
            end
        end
        @(negedge clk);
        start_i = 0;
        clear_i = 0;
    endtask

    task automatic launch(bit er, int a, int d, int w, int b);
        start_i = 1; op_erase_i = er; op_addr_i = 6'(a); op_data_i = 8'(d);
        work_i = 8'(w); budget_i = 8'(b);
        tick(1'b0, a);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        for (int i = 0; i < 64; i++) mem[i] = 8'hFF;
        m_busy = 0; m_err = 0; m_tog = 0; m_erase = 0;
        m_addr = 0; m_data = 0; m_cnt = 0; m_work = 0; m_budget = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy_o), 0);
        for (int i = 0; i < 64; i++) begin
            tick(1'b1, i);
            chk("R1 erased after reset", int'(seen), 8'hFF);
        end

        // Program A5 to byte 5; start and clear while busy are ignored
        launch(1'b0, 5, 8'hA5, 6, 10);
        tick(1'b1, 5);
        chk("R3 first status read", int'(seen), 8'h00);
        tick(1'b1, 5);
        chk("R3 toggled", int'(seen), 8'h40);
        tick(1'b0, 5);
        start_i = 1; op_erase_i = 0; op_addr_i = 6'd7; op_data_i = 8'h00;
        clear_i = 1;
        tick(1'b0, 5);
        chk("R3 no strobe keeps bit6", int'(seen), 8'h00);
        tick(1'b1, 6);
        chk("R8 outside region", int'(seen), 8'hFF);
        n = 5;
        while (busy_o && n < 100) begin tick(1'b1, 5); n++; end
        chk("R4 busy length", n, 6);
        tick(1'b1, 5);
        chk("R4 program result", int'(seen), 8'hA5);
        tick(1'b1, 7);
        chk("R2 ignored start", int'(seen), 8'hFF);

        // Conflict: 5A raises cleared bits of A5
        launch(1'b0, 5, 8'h5A, 3, 10);
        tick(1'b1, 5);
        chk("R5 conflict error", int'(seen), 8'h20);
        repeat (12) tick(1'b1, 5);
        chk("R5 held busy", int'(busy_o), 1);
        clear_i = 1;
        tick(1'b0, 0);
        tick(1'b1, 5);
        chk("R9 cleared", int'(busy_o), 0);
        chk("R5 array unchanged", int'(seen), 8'hA5);
        clear_i = 1;
        tick(1'b1, 5);
        tick(1'b1, 5);
        chk("R9 idle clear ignored", int'(seen), 8'hA5);

        // Tie: work equals budget, completion wins
        launch(1'b0, 5, 8'h21, 1, 1);
        tick(1'b1, 5);
        tick(1'b1, 5);
        chk("R4 tie completes", int'(seen), 8'h21);

        // Program time-out
        launch(1'b0, 9, 8'h0F, 20, 4);
        for (int i = 1; i <= 5; i++) begin
            tick(1'b1, 9);
            if (i == 4) chk("R6 before budget", int'(seen[5]), 0);
            if (i == 5) chk("R6 timeout flag", int'(seen[5]), 1);
        end
        repeat (4) tick(1'b1, 9);
        clear_i = 1;
        tick(1'b0, 9);
        tick(1'b1, 9);
        chk("R9 array after timeout", int'(seen), 8'hFF);

        // Erase sector 0
        launch(1'b0, 12, 8'h3C, 2, 5);
        repeat (3) tick(1'b1, 12);
        chk("R4 second program", int'(seen), 8'h3C);
        launch(1'b1, 3, 0, 5, 9);
        tick(1'b1, 12);
        chk("R7 sector status", int'(seen), 8'h00);
        tick(1'b1, 0);
        chk("R7 sector status other byte", int'(seen), 8'h40);
        tick(1'b1, 20);
        chk("R8 outside sector", int'(seen), 8'hFF);
        while (busy_o) tick(1'b1, 15);
        tick(1'b1, 5);
        chk("R7 erased byte 5", int'(seen), 8'hFF);
        tick(1'b1, 12);
        chk("R7 erased byte 12", int'(seen), 8'hFF);

        // Erase time-out in sector 2
        launch(1'b0, 40, 8'h11, 2, 4);
        repeat (3) tick(1'b1, 40);
        launch(1'b1, 33, 0, 9, 3);
        repeat (6) tick(1'b1, 47);
        chk("R6 erase timeout", int'(seen[5]), 1);
        clear_i = 1;
        tick(1'b0, 0);
        tick(1'b1, 40);
        chk("R9 erase abort keeps data", int'(seen), 8'h11);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule